// File: doc/BRIEF.md
# Register Port Lockout Key Gate

This block sits between a serial control port and a small byte-wide register file and decides, access by access, what the port may touch. When the stored lockout bit is set, the port comes up locked. While it is locked, reads of the protected shadow range come back as zero, and writes to the configuration register and the four key registers never reach the register file. Writes to the other shadow registers and to test space still go through.

To open the port, the host writes the stored 32-bit key, one byte per key register, in strictly ascending address order. When the mode bit is set, four coefficient bytes follow the base key, and their order is fixed. Writes to addresses outside the sequence may be interleaved and do not disturb it. One wrong byte, or one write to a sequence address that is out of turn, hard-locks the port until reset. A completed sequence keeps the port open for the rest of the session.

All gating is combinational from the current request and the registered lock state, so a blocked write is suppressed in the same cycle it is presented.

Top module: `regport_lock_gate`

## Requirements
- R1: After reset `locked` equals `cfg_lockout`, `hard_locked` is 0 and the sequence starts at the first key byte. With `cfg_lockout` at 0, `wr_en_gated` follows `wr_en` and `rd_data` follows `rd_raw` for every address.
- R2: The expected byte for key address 0x01 is `stored_key[31:24]`, for 0x02 it is `[23:16]`, for 0x03 `[15:8]` and for 0x04 `[7:0]`.
- R3: With `cfg_mode` at 0, correct writes to 0x01, 0x02, 0x03 and 0x04 in that order clear `locked` in the cycle after the fourth write.
- R4: With `cfg_mode` at 1, the base key is followed by writes to 0x09, 0x0A, 0x0F and 0x10, checked against `stored_ext[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. `locked` stays 1 until the cycle after the eighth correct write.
- R5: While locked, a write to an active sequence address that is not the expected next address, or that carries the wrong byte, raises `hard_locked` in the next cycle. Once `hard_locked` is set, no later writes unlock the port, and only reset clears it.
- R6: While locked, a read of any address from 0x00 to 0x1F returns 0x00 on `rd_data`. Reads from 0x20 and above return `rd_raw`.
- R7: While locked, writes to 0x00 through 0x04 are held off `wr_en_gated`. Writes to any other address pass through.
- R8: While the sequence is in progress, writes to addresses outside the active sequence neither advance it nor break it.
- R9: Once unlocked, the port stays unlocked until reset. All reads and writes then pass unchanged, and key writes are no longer compared.
- R10: `wr_en_gated` and `rd_data` respond in the same cycle as the request, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lockout | input | 1 | Stored lockout-enable bit |
| cfg_mode | input | 1 | Stored mode bit that adds the coefficient extension |
| stored_key | input | 32 | Stored base key |
| stored_ext | input | 32 | Stored coefficient bytes used as the key extension |
| wr_en | input | 1 | Write request strobe |
| wr_addr | input | 7 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 7 | Read register address |
| rd_raw | input | 8 | Unmasked read data from the register file |
| wr_en_gated | output | 1 | Write enable passed to the register file |
| rd_data | output | 8 | Masked read data returned to the port |
| locked | output | 1 | Port currently locked |
| hard_locked | output | 1 | A wrong attempt has been seen since reset |

## Verification
The assertions assume that `cfg_lockout`, `cfg_mode`, `stored_key` and `stored_ext` are constant between resets, because the stored configuration is loaded before the port becomes active. The stimulus changes these inputs only while reset is asserted. Inside each session it mixes correct next-key writes, occasional corrupted bytes and random accesses across the register space. Mid-sequence mode changes are never generated, so the sequence length seen by the tracker is fixed for each session.

// File: rtl/regport_lock_pkg.sv
package regport_lock_pkg;

  localparam int unsigned RA_W     = 7;
  localparam int unsigned RD_W     = 8;
  localparam int unsigned BASE_LEN = 4;
  localparam int unsigned EXT_LEN  = 4;
  localparam int unsigned SEQ_MAX  = BASE_LEN + EXT_LEN;
  localparam int unsigned KEY_W    = RD_W * BASE_LEN;
  localparam int unsigned EXT_W    = RD_W * EXT_LEN;

  typedef logic [RA_W-1:0] reg_addr_t;
  typedef logic [RD_W-1:0] reg_byte_t;

  // Register address expected at each position of the unlock sequence.
  function automatic reg_addr_t seq_addr(input int unsigned idx);
    case (idx)
      0:       return 7'h01;
      1:       return 7'h02;
      2:       return 7'h03;
      3:       return 7'h04;
      4:       return 7'h09;
      5:       return 7'h0A;
      6:       return 7'h0F;
      default: return 7'h10;
    endcase
  endfunction

  // Number of bytes in the sequence for the given mode bit.
  function automatic int unsigned seq_len(input logic mode);
    return mode ? SEQ_MAX : BASE_LEN;
  endfunction

  // Expected byte at a sequence position, most significant byte first.
  function automatic reg_byte_t seq_byte(input int unsigned idx,
                                         input logic [KEY_W-1:0] key,
                                         input logic [EXT_W-1:0] ext);
    logic [KEY_W-1:0] k_sh;
    logic [EXT_W-1:0] e_sh;
    k_sh = key >> (RD_W * (BASE_LEN - 1 - (idx % BASE_LEN)));
    e_sh = ext >> (RD_W * (EXT_LEN - 1 - (idx % EXT_LEN)));
    return (idx < BASE_LEN) ? k_sh[RD_W-1:0] : e_sh[RD_W-1:0];
  endfunction

endpackage

// File: rtl/lock_addr_decode.sv
module lock_addr_decode
  import regport_lock_pkg::*;
#(
  parameter int unsigned PTR_W     = 4,
  parameter reg_addr_t   NV_TOP    = 7'h1F,
  parameter reg_addr_t   GUARD_TOP = 7'h04
) (
  input  logic             cfg_mode,
  input  logic [PTR_W-1:0] ptr,
  input  reg_addr_t        wr_addr,
  input  reg_addr_t        rd_addr,
  input  logic [KEY_W-1:0] stored_key,
  input  logic [EXT_W-1:0] stored_ext,
  output logic             in_seq,
  output logic             exp_hit,
  output reg_byte_t        exp_byte,
  output logic             guard_wr,
  output logic             prot_rd
);

  logic [SEQ_MAX-1:0] slot_hit;

  for (genvar j = 0; j < SEQ_MAX; j++) begin : g_slot
    assign slot_hit[j] = (wr_addr == seq_addr(j)) && (j < seq_len(cfg_mode));
  end

  assign in_seq   = |slot_hit;
  assign exp_hit  = (wr_addr == seq_addr(32'(ptr)));
  assign exp_byte = seq_byte(32'(ptr), stored_key, stored_ext);
  assign guard_wr = (wr_addr <= GUARD_TOP);
  assign prot_rd  = (rd_addr <= NV_TOP);

endmodule

// File: rtl/lock_seq_tracker.sv
module lock_seq_tracker
  import regport_lock_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_lockout,
  input  logic             cfg_mode,
  input  logic             wr_en,
  input  reg_byte_t        wr_data,
  input  logic             in_seq,
  input  logic             exp_hit,
  input  reg_byte_t        exp_byte,
  output logic [PTR_W-1:0] ptr,
  output logic             unlocked,
  output logic             hard,
  output logic             seq_good,
  output logic             seq_bad,
  output logic             seq_done
);

  logic armed;
  logic seq_step;
  logic at_last;

  assign armed    = cfg_lockout && !unlocked && !hard;
  assign seq_step = armed && wr_en && in_seq;
  assign seq_good = seq_step && exp_hit && (wr_data == exp_byte);
  assign seq_bad  = seq_step && !seq_good;
  assign at_last  = (ptr == PTR_W'(seq_len(cfg_mode) - 1));
  assign seq_done = seq_good && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      unlocked <= 1'b0;
      hard     <= 1'b0;
    end else begin
      if (seq_bad)  hard     <= 1'b1;
      if (seq_good) ptr      <= ptr + 1'b1;
      if (seq_done) unlocked <= 1'b1;
    end
  end

endmodule

// File: rtl/lock_access_gate.sv
module lock_access_gate
  import regport_lock_pkg::*;
(
  input  logic      cfg_lockout,
  input  logic      unlocked,
  input  logic      wr_en,
  input  logic      guard_wr,
  input  logic      prot_rd,
  input  reg_byte_t rd_raw,
  output logic      locked,
  output logic      wr_en_gated,
  output reg_byte_t rd_data
);

  assign locked      = cfg_lockout && !unlocked;
  assign wr_en_gated = wr_en && !(locked && guard_wr);
  assign rd_data     = (locked && prot_rd) ? '0 : rd_raw;

endmodule

// File: rtl/regport_lock_gate.sv
module regport_lock_gate
  import regport_lock_pkg::*;
#(
  parameter reg_addr_t NV_TOP    = 7'h1F,
  parameter reg_addr_t GUARD_TOP = 7'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_lockout,
  input  logic             cfg_mode,
  input  logic [KEY_W-1:0] stored_key,
  input  logic [EXT_W-1:0] stored_ext,
  input  logic             wr_en,
  input  reg_addr_t        wr_addr,
  input  reg_byte_t        wr_data,
  input  reg_addr_t        rd_addr,
  input  reg_byte_t        rd_raw,
  output logic             wr_en_gated,
  output reg_byte_t        rd_data,
  output logic             locked,
  output logic             hard_locked
);

  localparam int unsigned PTR_W = $clog2(SEQ_MAX) + 1;

  logic [PTR_W-1:0] ptr;
  logic             in_seq;
  logic             exp_hit;
  reg_byte_t        exp_byte;
  logic             guard_wr;
  logic             prot_rd;
  logic             unlocked;
  logic             hard;
  logic             seq_good;
  logic             seq_bad;
  logic             seq_done;

  lock_addr_decode #(
    .PTR_W(PTR_W), .NV_TOP(NV_TOP), .GUARD_TOP(GUARD_TOP)
  ) i_decode (
    .cfg_mode(cfg_mode), .ptr(ptr), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .stored_key(stored_key), .stored_ext(stored_ext),
    .in_seq(in_seq), .exp_hit(exp_hit), .exp_byte(exp_byte),
    .guard_wr(guard_wr), .prot_rd(prot_rd)
  );

  lock_seq_tracker #(
    .PTR_W(PTR_W)
  ) i_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_lockout(cfg_lockout), .cfg_mode(cfg_mode),
    .wr_en(wr_en), .wr_data(wr_data), .in_seq(in_seq), .exp_hit(exp_hit),
    .exp_byte(exp_byte), .ptr(ptr), .unlocked(unlocked), .hard(hard),
    .seq_good(seq_good), .seq_bad(seq_bad), .seq_done(seq_done)
  );

  lock_access_gate i_gate (
    .cfg_lockout(cfg_lockout), .unlocked(unlocked), .wr_en(wr_en),
    .guard_wr(guard_wr), .prot_rd(prot_rd), .rd_raw(rd_raw),
    .locked(locked), .wr_en_gated(wr_en_gated), .rd_data(rd_data)
  );

  assign hard_locked = hard;

endmodule

// File: rtl/regport_lock_checker.sv
module regport_lock_checker
  import regport_lock_pkg::*;
#(
  parameter reg_addr_t NV_TOP    = 7'h1F,
  parameter reg_addr_t GUARD_TOP = 7'h04
) (
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_lockout,
  input logic      wr_en,
  input reg_addr_t wr_addr,
  input reg_addr_t rd_addr,
  input logic      wr_en_gated,
  input reg_byte_t rd_data,
  input logic      locked,
  input logic      hard_locked,
  input logic      unlocked,
  input logic      seq_bad,
  input logic      seq_done
);

  assert_hard_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hard_locked |=> hard_locked);

  assert_bad_sets_hard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_bad |=> hard_locked);

  assert_hard_keeps_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_locked && cfg_lockout) |-> locked);

  assert_done_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !locked);

  assert_open_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  assert_guard_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_addr <= GUARD_TOP) |-> !wr_en_gated);

  assert_free_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr > GUARD_TOP) |-> (wr_en_gated == wr_en));

  assert_prot_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rd_addr <= NV_TOP) |-> (rd_data == '0));

endmodule

bind regport_lock_gate regport_lock_checker #(
  .NV_TOP(NV_TOP), .GUARD_TOP(GUARD_TOP)
) i_checker (
  .clk(clk), .rst_n(rst_n), .cfg_lockout(cfg_lockout), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_en_gated(wr_en_gated),
  .rd_data(rd_data), .locked(locked), .hard_locked(hard_locked),
  .unlocked(unlocked), .seq_bad(seq_bad), .seq_done(seq_done)
);

// File: tb/test_regport_lock_gate.sv
module test_regport_lock_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_lockout = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [31:0] stored_key = '0;
  logic [31:0] stored_ext = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  rd_raw = '0;
  logic        wr_en_gated;
  logic [7:0]  rd_data;
  logic        locked;
  logic        hard_locked;

  always #4 clk = ~clk;

  regport_lock_gate i_regport_lock_gate (
    .clk(clk), .rst_n(rst_n), .cfg_lockout(cfg_lockout), .cfg_mode(cfg_mode),
    .stored_key(stored_key), .stored_ext(stored_ext), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_raw(rd_raw),
    .wr_en_gated(wr_en_gated), .rd_data(rd_data), .locked(locked),
    .hard_locked(hard_locked)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic m_unl, m_hard;
  int m_ptr;

  function automatic logic [6:0] b_addr(int i);
    case (i)
      0: return 7'd1;  1: return 7'd2;  2: return 7'd3;  3: return 7'd4;
      4: return 7'd9;  5: return 7'd10; 6: return 7'd15; default: return 7'd16;
    endcase
  endfunction

  function automatic logic [7:0] b_byte(int i);
    logic [31:0] w;
    w = (i < 4) ? stored_key : stored_ext;
    case (i % 4)
      0: return w[31:24];
      1: return w[23:16];
      2: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  function automatic int b_len();
    return cfg_mode ? 8 : 4;
  endfunction

  function automatic logic b_locked();
    return cfg_lockout && !m_unl;
  endfunction

  function automatic logic b_in_seq(logic [6:0] a);
    for (int j = 0; j < b_len(); j++)
      if (b_addr(j) == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic lo, logic md, logic [31:0] k, logic [31:0] e);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    cfg_lockout = lo; cfg_mode = md; stored_key = k; stored_ext = e;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_unl = 1'b0; m_hard = 1'b0; m_ptr = 0;
    #1;
    chk("R1", {31'd0, locked}, {31'd0, lo});
    chk("R1", {31'd0, hard_locked}, 32'd0);
  endtask

  task automatic step(logic we, logic [6:0] wa, logic [7:0] wd, logic [6:0] ra);
    string tg;
    logic bl;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; rd_raw = 8'($urandom);
    #1;
    bl = b_locked();
    tg = bl ? "R7" : (cfg_lockout ? "R9" : "R1");
    chk(tg, {31'd0, wr_en_gated}, {31'd0, we && !(bl && wa <= 7'd4)});
    tg = bl ? "R6" : (cfg_lockout ? "R9" : "R1");
    chk(tg, {24'd0, rd_data}, {24'd0, (bl && ra <= 7'h1F) ? 8'd0 : rd_raw});
    chk(m_hard ? "R5" : "R3", {31'd0, locked}, {31'd0, bl});
    chk("R5", {31'd0, hard_locked}, {31'd0, m_hard});
    if (we && bl && !m_hard && b_in_seq(wa)) begin
      if (m_ptr < b_len() && wa == b_addr(m_ptr) && wd == b_byte(m_ptr)) begin
        m_ptr++;
        if (m_ptr == b_len()) m_unl = 1'b1;
      end else begin
        m_hard = 1'b1;
      end
    end
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic write_key(int from, int upto);
    for (int i = from; i < upto; i++) step(1'b1, b_addr(i), b_byte(i), 7'h00);
  endtask

  task automatic probe(string tag, logic exp_lock, logic exp_hard);
    @(negedge clk);
    #1;
    chk(tag, {31'd0, locked}, {31'd0, exp_lock});
    chk(tag, {31'd0, hard_locked}, {31'd0, exp_hard});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1: lockout disabled, everything passes
    do_reset(1'b0, 1'b0, 32'hA1B2C3D4, 32'h11223344);
    step(1'b1, 7'h01, 8'h55, 7'h03);
    step(1'b1, 7'h00, 8'h01, 7'h10);

    // R3, R8, R10: ordered key with interleaved foreign writes
    do_reset(1'b1, 1'b0, 32'hA1B2C3D4, 32'h11223344);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'h02; wr_data = 8'hFF; rd_addr = 7'h05; #1;
    chk("R10", {31'd0, wr_en_gated}, 32'd0);
    wr_en = 1'b0; #1;
    write_key(0, 2);
    step(1'b1, 7'h05, 8'h77, 7'h00);
    step(1'b1, 7'h22, 8'h78, 7'h00);
    probe("R8", 1'b1, 1'b0);
    write_key(2, 4);
    probe("R3", 1'b0, 1'b0);
    step(1'b1, 7'h02, 8'h00, 7'h10);
    probe("R9", 1'b0, 1'b0);

    // R4: extended sequence
    do_reset(1'b1, 1'b1, 32'h0F1E2D3C, 32'h4B5A6978);
    write_key(0, 4);
    probe("R4", 1'b1, 1'b0);
    write_key(4, 8);
    probe("R4", 1'b0, 1'b0);

    // R2: byte order of the key
    do_reset(1'b1, 1'b0, 32'h12345678, 32'h0);
    step(1'b1, 7'h01, 8'h78, 7'h00);
    probe("R2", 1'b1, 1'b1);

    // R5: out-of-order write, then correct key has no effect, reset clears
    do_reset(1'b1, 1'b0, 32'hCAFEBABE, 32'h0);
    step(1'b1, 7'h02, 8'hFE, 7'h00);
    write_key(0, 4);
    probe("R5", 1'b1, 1'b1);
    do_reset(1'b1, 1'b0, 32'hCAFEBABE, 32'h0);
    probe("R5", 1'b1, 1'b0);

    // Random sessions
    for (int s = 0; s < 30; s++) begin
      do_reset(($urandom % 4) != 0, 1'($urandom), $urandom, $urandom);
      for (int k = 0; k < 200; k++) begin
        int r;
        r = $urandom % 10;
        if (r < 6) begin
          int p;
          logic [7:0] d;
          p = (m_ptr < b_len()) ? m_ptr : 0;
          d = b_byte(p);
          if (($urandom % 25) == 0) d = d ^ 8'h01;
          step(1'b1, b_addr(p), d, 7'($urandom % 64));
        end else if (r == 6) begin
          step(1'b1, 7'($urandom % 64), 8'($urandom), 7'($urandom % 64));
        end else begin
          step(1'b0, 7'($urandom % 64), 8'($urandom), 7'($urandom % 64));
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule